// File: doc/BRIEF.md
# SDRAM Read Data Pipeline with CAS Latency

This block times the read data side of a synchronous DRAM style interface. It may take a read command in any cycle, even while an earlier burst is still coming out. Each read produces its burst of beats a programmed number of cycles (the CAS latency) after the command. The burst length, ordering and latency come from mode settings that are sampled along with each read. There is no storage array. Each beat reports the column it addresses, and that column index stands in for the data word.

A read issued while an older burst is running cuts off the rest of the older burst, and the cut falls in the same latency-shifted cycle as the new burst's first beat. A burst-stop command or a precharge of the open bank ends output the same way, with the same latency. A data-mask input lets the controller turn the data bus around: a mask in one cycle blanks the output enable two cycles later, and the burst keeps stepping through its columns. Reserved latency or length codes raise a configuration error and fall back to a defined value.

Top module: `sdr_read_pipe`

## Requirements
- R1: While reset is held and in the first cycle after release, `rd_beat_o` and `rd_oe_o` are 0 and `rd_col_o` is 0.
- R2: A read sampled in cycle c produces its first beat in cycle c+CL, and `rd_col_o` equals the column given with the read. The latency codes 3'b001, 3'b010 and 3'b011 select CL = 1, 2 and 3. The latency setting is held constant while reads are in flight.
- R3: The burst length code sampled with the read sets the beat count: 3'b000 → 1, 3'b001 → 2, 3'b010 → 4, 3'b011 → 8. The beats fall in consecutive cycles, and the cycle after the last beat has no beat.
- R4: With ordering bit `ilv_i` = 0, beat k of a length-L burst addresses (col & ~(L-1)) | ((col + k) & (L-1)). The burst wraps inside its aligned block, so L=4 from column 5 gives 5,6,7,4.
- R5: With `ilv_i` = 1, beat k addresses (col & ~(L-1)) | ((col ^ k) & (L-1)). L=8 from column 5 gives 5,4,7,6,1,0,3,2.
- R6: Length code 3'b111 gives a whole-row burst. The column steps up by one each cycle, wraps modulo 2^COL_W, and continues until a read, burst stop or precharge cuts it. Ordering is always ascending for this length.
- R7: A read sampled in cycle c while an older burst is active replaces the older burst's beats from cycle c+CL onward.
- R8: A `stop_i` or `pre_i` sampled in cycle c, with no read in that cycle, suppresses every beat from cycle c+CL onward until a later read. If a read arrives in the same cycle as a stop or precharge, the read wins.
- R9: `dqm_i` sampled in cycle t forces `rd_oe_o` to 0 in cycle t+2. `rd_beat_o` and `rd_col_o` still show the beat, and the burst's column sequence is unchanged. `rd_oe_o` is 1 only when `rd_beat_o` is 1.
- R10: Latency codes 3'b000 and 3'b100 to 3'b111 set `cfg_err_o` combinationally and behave as CL = 3.
- R11: Length codes 3'b100, 3'b101 and 3'b110 set `cfg_err_o` combinationally and give a single-beat burst.
- R12: In any cycle without a beat, `rd_col_o` is 0 and `rd_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_i | input | 1 | Read command strobe |
| stop_i | input | 1 | Burst-stop command strobe |
| pre_i | input | 1 | Precharge of the bank holding the open burst |
| col_i | input | COL_W | Start column of the read |
| cl_code_i | input | 3 | CAS latency code from the mode setting |
| bl_code_i | input | 3 | Burst length code from the mode setting |
| ilv_i | input | 1 | Burst ordering: 0 ascending-wrap, 1 interleaved |
| dqm_i | input | 1 | Data mask; blanks the output enable two cycles later |
| rd_beat_o | output | 1 | A burst beat occupies this cycle |
| rd_oe_o | output | 1 | Data bus is driven this cycle |
| rd_col_o | output | COL_W | Column index (the modelled data) of the beat |
| cfg_err_o | output | 1 | Reserved latency or length code present |

## Verification
Several behaviours are checked by assertions on every clock. The output enable never rises without a beat, and an idle cycle shows a zero column. A latency-aligned event in the engine always launches or silences the next beat. A whole-row burst steps by exactly one column per beat, and a mask three sampled edges back always blanks the output enable. Other behaviours can only be shown by the bench's directed scenarios, each compared against hand-derived cycle tables: exact latency for each code, the ascending and interleaved orders at block edges, truncation of a burst by a later read, stop or precharge, and the fallback for reserved codes.

// File: rtl/sdr_rdpipe_pkg.sv
package sdr_rdpipe_pkg;

    // Burst length selection after decoding the mode code
    typedef enum logic [2:0] {
        BL_ONE   = 3'd0,
        BL_TWO   = 3'd1,
        BL_FOUR  = 3'd2,
        BL_EIGHT = 3'd3,
        BL_ROW   = 3'd4
    } blen_e;

    // Command event carried down the latency line
    typedef struct packed {
        logic  rd;
        logic  stop;
        logic  ilv;
        blen_e blen;
    } cmd_t;

    localparam int unsigned CMD_W = $bits(cmd_t);

    // Latency in cycles; reserved codes fall back to three
    function automatic logic [1:0] cl_decode(input logic [2:0] code);
        case (code)
            3'b001:  return 2'd1;
            3'b010:  return 2'd2;
            3'b011:  return 2'd3;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic cl_reserved(input logic [2:0] code);
        return !(code inside {3'b001, 3'b010, 3'b011});
    endfunction

    // Length selection; reserved codes fall back to one beat
    function automatic blen_e bl_decode(input logic [2:0] code);
        case (code)
            3'b000:  return BL_ONE;
            3'b001:  return BL_TWO;
            3'b010:  return BL_FOUR;
            3'b011:  return BL_EIGHT;
            3'b111:  return BL_ROW;
            default: return BL_ONE;
        endcase
    endfunction

    function automatic logic bl_reserved(input logic [2:0] code);
        return code inside {3'b100, 3'b101, 3'b110};
    endfunction

endpackage

// File: rtl/sdr_cmd_delay.sv
module sdr_cmd_delay #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 3,
    parameter int unsigned SEL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     din,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     tap
);

    logic [W-1:0] stage_d [DEPTH];
    logic [W-1:0] stage_q [DEPTH];

    // Next value of every stage: newest entry at index zero
    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    // Stage sel-1 holds the command sampled sel edges ago
    always_comb begin
        tap = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel == SEL_W'(i + 1)) begin
                tap = stage_q[i];
            end
        end
    end

    // R10: every latency, including fallbacks, selects a real stage
    p_tap_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel >= SEL_W'(1)) && (sel <= SEL_W'(DEPTH)))
        else $error("latency tap out of range");

endmodule

// File: rtl/sdr_beat_col.sv
module sdr_beat_col
    import sdr_rdpipe_pkg::*;
#(
    parameter int unsigned COL_W = 9
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] idx,
    input  blen_e            blen,
    input  logic             ilv,
    output logic [COL_W-1:0] col,
    output logic             last
);

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] offs;
    logic             row;

    always_comb begin
        case (blen)
            BL_TWO:   mask = COL_W'(1);
            BL_FOUR:  mask = COL_W'(3);
            BL_EIGHT: mask = COL_W'(7);
            BL_ROW:   mask = '1;
            default:  mask = '0;
        endcase
        row = (blen == BL_ROW);
        if (ilv && !row) begin
            offs = (start ^ idx) & mask;
        end else begin
            offs = (start + idx) & mask;
        end
        col  = (start & ~mask) | offs;
        last = !row && (idx == mask);
    end

endmodule

// File: rtl/sdr_beat_engine.sv
module sdr_beat_engine
    import sdr_rdpipe_pkg::*;
#(
    parameter int unsigned COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_t             ev_i,
    input  logic [COL_W-1:0] ev_col_i,
    input  logic             dqm_i,
    output logic             beat_o,
    output logic             oe_o,
    output logic [COL_W-1:0] col_o
);

    localparam int unsigned MASK_LAG = 2;

    typedef struct packed {
        logic                active;
        logic [COL_W-1:0]    start;
        logic [COL_W-1:0]    idx;
        blen_e               blen;
        logic                ilv;
        logic [MASK_LAG-1:0] mask;
        logic                beat;
        logic                oe;
        logic [COL_W-1:0]    col;
    } eng_t;

    eng_t st_d, st_q;

    logic [COL_W-1:0] g_start, g_idx, g_col;
    blen_e            g_blen;
    logic             g_ilv, g_last;

    // Column generator input: a fresh read or the running burst
    always_comb begin
        if (ev_i.rd) begin
            g_start = ev_col_i;
            g_idx   = '0;
            g_blen  = ev_i.blen;
            g_ilv   = ev_i.ilv;
        end else begin
            g_start = st_q.start;
            g_idx   = st_q.idx;
            g_blen  = st_q.blen;
            g_ilv   = st_q.ilv;
        end
    end

    sdr_beat_col #(.COL_W(COL_W)) u_col (
        .start (g_start),
        .idx   (g_idx),
        .blen  (g_blen),
        .ilv   (g_ilv),
        .col   (g_col),
        .last  (g_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mask = {st_q.mask[MASK_LAG-2:0], dqm_i};
        st_d.beat = 1'b0;
        st_d.col  = '0;
        if (ev_i.rd) begin
            st_d.beat   = 1'b1;
            st_d.col    = g_col;
            st_d.active = !g_last;
            st_d.start  = ev_col_i;
            st_d.idx    = COL_W'(1);
            st_d.blen   = ev_i.blen;
            st_d.ilv    = ev_i.ilv;
        end else if (ev_i.stop) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            st_d.beat   = 1'b1;
            st_d.col    = g_col;
            st_d.active = !g_last;
            st_d.idx    = st_q.idx + COL_W'(1);
        end
        st_d.oe = st_d.beat & ~st_q.mask[MASK_LAG-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_o = st_q.beat;
    assign oe_o   = st_q.oe;
    assign col_o  = st_q.col;

    // R2: an aligned read always opens a beat at its own column
    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i.rd |=> (beat_o && col_o == $past(ev_col_i)))
        else $error("aligned read did not launch");

    // R8: an aligned stop without a read silences the next beat
    p_stop_silences_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i.stop && !ev_i.rd) |=> !beat_o)
        else $error("beat after aligned stop");

    // R6: whole-row continuation steps by exactly one column
    p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_o && $past(beat_o) && !$past(ev_i.rd) && st_q.blen == BL_ROW)
        |-> (col_o == $past(col_o) + COL_W'(1)))
        else $error("row burst column step");

endmodule

// File: rtl/sdr_read_pipe.sv
module sdr_read_pipe
    import sdr_rdpipe_pkg::*;
#(
    parameter int unsigned COL_W  = 9,
    parameter int unsigned MAX_CL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_i,
    input  logic             stop_i,
    input  logic             pre_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [2:0]       cl_code_i,
    input  logic [2:0]       bl_code_i,
    input  logic             ilv_i,
    input  logic             dqm_i,
    output logic             rd_beat_o,
    output logic             rd_oe_o,
    output logic [COL_W-1:0] rd_col_o,
    output logic             cfg_err_o
);

    localparam int unsigned SEL_W = $clog2(MAX_CL + 1);
    localparam int unsigned VEC_W = CMD_W + COL_W;

    cmd_t             ev_in, ev_tap;
    logic [COL_W-1:0] col_tap;
    logic [VEC_W-1:0] vec_in, vec_tap;
    logic [SEL_W-1:0] lat_sel;

    always_comb begin
        ev_in.rd   = rd_i;
        ev_in.stop = stop_i | pre_i;
        ev_in.ilv  = ilv_i;
        ev_in.blen = bl_decode(bl_code_i);
        vec_in     = {ev_in, col_i};
        lat_sel    = SEL_W'(cl_decode(cl_code_i));
        cfg_err_o  = cl_reserved(cl_code_i) | bl_reserved(bl_code_i);
    end

    sdr_cmd_delay #(.W(VEC_W), .DEPTH(MAX_CL), .SEL_W(SEL_W)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (vec_in),
        .sel   (lat_sel),
        .tap   (vec_tap)
    );

    assign {ev_tap, col_tap} = vec_tap;

    sdr_beat_engine #(.COL_W(COL_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev_tap),
        .ev_col_i (col_tap),
        .dqm_i    (dqm_i),
        .beat_o   (rd_beat_o),
        .oe_o     (rd_oe_o),
        .col_o    (rd_col_o)
    );

    // Cycles since reset, saturating, so mask history is post-reset
    logic [1:0] live_d, live_q;

    always_comb begin
        live_d = (live_q == 2'd3) ? live_q : live_q + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else begin
            live_q <= live_d;
        end
    end

    // R9: the output enable needs a beat
    p_oe_in_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe_o |-> rd_beat_o)
        else $error("output enable without beat");

    // R9: a mask two cycles ahead of a beat keeps the bus undriven
    p_dqm_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd3 && $past(dqm_i, 3)) |-> !rd_oe_o)
        else $error("masked beat drove the bus");

    // R12: idle cycles show a zero column
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_beat_o |-> (rd_col_o == '0 && !rd_oe_o))
        else $error("idle cycle not quiet");

    // R2: at latency one the beat follows the read by one cycle
    p_cl1_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && cl_code_i == 3'b001 && $stable(cl_code_i))
        |=> ##1 (rd_beat_o && rd_col_o == $past(col_i, 2)))
        else $error("latency one read misplaced");

endmodule

// File: tb/sdr_read_pipe_test.sv
module sdr_read_pipe_test;

    localparam int COL_W = 9;
    localparam int NCYC  = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_i = 1'b0, stop_i = 1'b0, pre_i = 1'b0;
    logic             ilv_i = 1'b0, dqm_i = 1'b0;
    logic [COL_W-1:0] col_i = '0;
    logic [2:0]       cl_code_i = 3'b001, bl_code_i = 3'b000;
    logic             rd_beat_o, rd_oe_o, cfg_err_o;
    logic [COL_W-1:0] rd_col_o;

    always #5 clk = ~clk;

    sdr_read_pipe #(.COL_W(COL_W), .MAX_CL(3)) uut (
        .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .stop_i(stop_i), .pre_i(pre_i),
        .col_i(col_i), .cl_code_i(cl_code_i), .bl_code_i(bl_code_i),
        .ilv_i(ilv_i), .dqm_i(dqm_i), .rd_beat_o(rd_beat_o), .rd_oe_o(rd_oe_o),
        .rd_col_o(rd_col_o), .cfg_err_o(cfg_err_o)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    bit s_rd[NCYC], s_stop[NCYC], s_pre[NCYC], s_dqm[NCYC];
    int s_col[NCYC];
    bit o_beat[NCYC], o_oe[NCYC];
    int o_col[NCYC];

    task automatic clear_stim();
        for (int c = 0; c < NCYC; c++) begin
            s_rd[c] = 0; s_stop[c] = 0; s_pre[c] = 0; s_dqm[c] = 0; s_col[c] = 0;
        end
    endtask

    // Cycle c inputs are set before edge c; outputs read after it
    task automatic run();
        for (int c = 0; c < NCYC; c++) begin
            rd_i = s_rd[c]; stop_i = s_stop[c]; pre_i = s_pre[c];
            dqm_i = s_dqm[c]; col_i = COL_W'(s_col[c]);
            @(negedge clk);
            o_beat[c] = rd_beat_o; o_oe[c] = rd_oe_o; o_col[c] = int'(rd_col_o);
        end
        rd_i = 0; stop_i = 0; pre_i = 0; dqm_i = 0; col_i = '0;
    endtask

    task automatic check(string req, int c, bit b, bit oe, int col);
        n_chk++;
        if (o_beat[c] !== b || o_oe[c] !== oe || o_col[c] != col) begin
            n_bad++;
            $display("FAIL %s cycle %0d: got beat=%0b oe=%0b col=%0d, expected beat=%0b oe=%0b col=%0d",
                     req, c, o_beat[c], o_oe[c], o_col[c], b, oe, col);
        end
    endtask

    task automatic check_seq(string req, int first, int n, int cols[8]);
        check({req, "/R12"}, first - 1, 0, 0, 0);
        for (int k = 0; k < n; k++) check(req, first + k, 1, 1, cols[k]);
        check({req, "/R12"}, first + n, 0, 0, 0);
    endtask

    task automatic check_err(string req, bit exp);
        #1;
        n_chk++;
        if (cfg_err_o !== exp) begin
            n_bad++;
            $display("FAIL %s: got cfg_err=%0b, expected %0b", req, cfg_err_o, exp);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        n_chk++;
        if (rd_beat_o !== 0 || rd_oe_o !== 0 || rd_col_o !== '0) begin
            n_bad++;
            $display("FAIL R1 in reset: got %0b/%0b/%0d, expected 0/0/0", rd_beat_o, rd_oe_o, rd_col_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (rd_beat_o !== 0 || rd_oe_o !== 0 || rd_col_o !== '0) begin
            n_bad++;
            $display("FAIL R1 after release: got %0b/%0b/%0d, expected 0/0/0", rd_beat_o, rd_oe_o, rd_col_o);
        end
    endtask

    task automatic t_latency();
        for (int cl = 1; cl <= 3; cl++) begin
            cl_code_i = 3'(cl); bl_code_i = 3'b000; ilv_i = 0;
            check_err("R2 valid latency code", 0);
            clear_stim(); s_rd[2] = 1; s_col[2] = 10 + cl;
            run();
            check_seq("R2/R3 single beat", 2 + cl, 1, '{10 + cl, 0, 0, 0, 0, 0, 0, 0});
        end
    endtask

    task automatic t_sequential();
        cl_code_i = 3'b010; ilv_i = 0;
        bl_code_i = 3'b010; clear_stim(); s_rd[0] = 1; s_col[0] = 5; run();
        check_seq("R4 len4 from 5", 2, 4, '{5, 6, 7, 4, 0, 0, 0, 0});
        bl_code_i = 3'b011; clear_stim(); s_rd[0] = 1; s_col[0] = 13; run();
        check_seq("R3 len8 from 13", 2, 8, '{13, 14, 15, 8, 9, 10, 11, 12});
        bl_code_i = 3'b001; clear_stim(); s_rd[0] = 1; s_col[0] = 7; run();
        check_seq("R4 len2 from 7", 2, 2, '{7, 6, 0, 0, 0, 0, 0, 0});
    endtask

    task automatic t_interleave();
        cl_code_i = 3'b010; ilv_i = 1;
        bl_code_i = 3'b011; clear_stim(); s_rd[0] = 1; s_col[0] = 5; run();
        check_seq("R5 len8 from 5", 2, 8, '{5, 4, 7, 6, 1, 0, 3, 2});
        bl_code_i = 3'b010; clear_stim(); s_rd[0] = 1; s_col[0] = 6; run();
        check_seq("R5 len4 from 6", 2, 4, '{6, 7, 4, 5, 0, 0, 0, 0});
        ilv_i = 0;
    endtask

    task automatic t_row();
        cl_code_i = 3'b001; bl_code_i = 3'b111; ilv_i = 1;
        check_err("R6 row code legal", 0);
        clear_stim(); s_rd[0] = 1; s_col[0] = 509; s_stop[6] = 1; run();
        check_seq("R6 row wrap then stop", 1, 6, '{509, 510, 511, 0, 1, 2, 0, 0});
        ilv_i = 0;
    endtask

    task automatic t_cut();
        cl_code_i = 3'b011; bl_code_i = 3'b010;
        clear_stim(); s_rd[0] = 1; s_col[0] = 0; s_rd[2] = 1; s_col[2] = 20; run();
        check_seq("R7 newer read cuts burst", 3, 6, '{0, 1, 20, 21, 22, 23, 0, 0});
        for (int c = 10; c < 14; c++) check("R12 idle after burst", c, 0, 0, 0);
    endtask

    task automatic t_stop();
        cl_code_i = 3'b011; bl_code_i = 3'b011;
        clear_stim(); s_rd[0] = 1; s_col[0] = 0; s_stop[2] = 1; run();
        check_seq("R8 burst stop", 3, 2, '{0, 1, 0, 0, 0, 0, 0, 0});
        check("R8 stays stopped", 6, 0, 0, 0);
        check("R8 stays stopped", 10, 0, 0, 0);
        clear_stim(); s_rd[0] = 1; s_col[0] = 16; s_pre[2] = 1; run();
        check_seq("R8 precharge", 3, 2, '{16, 17, 0, 0, 0, 0, 0, 0});
        cl_code_i = 3'b010; bl_code_i = 3'b010;
        clear_stim(); s_rd[0] = 1; s_col[0] = 8; s_stop[0] = 1; run();
        check_seq("R8 read wins over stop", 2, 4, '{8, 9, 10, 11, 0, 0, 0, 0});
    endtask

    task automatic t_dqm();
        cl_code_i = 3'b010; bl_code_i = 3'b010;
        clear_stim(); s_rd[0] = 1; s_col[0] = 0; s_dqm[1] = 1; s_dqm[3] = 1; s_dqm[8] = 1; run();
        check("R9 masked beat", 3, 1, 0, 1);
        check("R9 unmasked beat", 2, 1, 1, 0);
        check("R9 unmasked beat", 4, 1, 1, 2);
        check("R9 masked last beat", 5, 1, 0, 3);
        check("R9 burst ends", 6, 0, 0, 0);
        check("R9 mask in idle", 10, 0, 0, 0);
    endtask

    task automatic t_reserved();
        bl_code_i = 3'b000;
        cl_code_i = 3'b000;
        check_err("R10 latency code 000", 1);
        clear_stim(); s_rd[0] = 1; s_col[0] = 33; run();
        check_seq("R10 fallback latency 3", 3, 1, '{33, 0, 0, 0, 0, 0, 0, 0});
        cl_code_i = 3'b110;
        check_err("R10 latency code 110", 1);
        cl_code_i = 3'b001; bl_code_i = 3'b101;
        check_err("R11 length code 101", 1);
        clear_stim(); s_rd[0] = 1; s_col[0] = 40; run();
        check_seq("R11 fallback one beat", 1, 1, '{40, 0, 0, 0, 0, 0, 0, 0});
        bl_code_i = 3'b000;
        check_err("R11 length code 000", 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got no completion, expected end of scenarios");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_latency();
        t_sequential();
        t_interleave();
        t_row();
        t_cut();
        t_stop();
        t_dqm();
        t_reserved();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule